// File: doc/BRIEF.md
# Register Write Completion Status Tracker

This block tells software when a write to a timer register has reached the timer logic. It watches the bus-side write strobe and address. When the address names a tracked register, it sends a one-cycle apply pulse on that register's line after a fixed number of cycles. This delay stands in for the crossing into a slower timer clock. In the cycle after the pulse, the block sets a sticky bit for that register in a status word.

Software polls the status word until the bit is set. It then writes a 1 to the bit to clear it. Two shared status words cover the global registers: one for the free-running count halves and one for the comparator and global control. Each local channel has its own status word. The delay is a parameter and stays at a few cycles, far below the roughly one-millisecond window that software allows.

Top module: `wst_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status bit and every apply line is 0 after that edge.
- R2: A write to a tracked address drives exactly that register's `apply_o` line high for one cycle. The pulse appears LAT cycles after the cycle in which the strobe was sampled. Lines and addresses are: 0 count low 0x100, 1 count high 0x104, 2 compare low 0x200, 3 compare high 0x204, 4 compare increment 0x208, 5 global control 0x240, then three lines per channel c: tick buffer 0x300+0x100*c, interrupt count buffer 0x308+0x100*c, local control 0x320+0x100*c.
- R3: A register's status bit goes to 1 in the cycle after its apply pulse and stays 1 until it is cleared. The bit positions are as follows. `gstat_o` uses bit 0 for compare low, bit 1 for compare high, bit 2 for the increment register and bit 16 for global control. `cstat_o` uses bit 0 for count low and bit 1 for count high. Each 32-bit channel slice of `lstat_o` uses bit 0 for the tick buffer, bit 1 for the interrupt count buffer and bit 3 for local control.
- R4: A write to a status word clears every tracked bit whose data bit is 1. It leaves bits written with 0 unchanged. The status words are at 0x24C (global), 0x110 (count) and 0x340+0x100*c (channel c).
- R5: A write to any address outside the tracked list creates no apply pulse and sets no status bit.
- R6: When a clear and an apply for the same bit land in the same cycle, the bit ends up set.
- R7: Writes on consecutive cycles are each tracked, each with its own pulse and status bit after the same latency.
- R8: Status bit positions that track no register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data; used as the clear mask for status words |
| apply_o | output | 6+3*NCH | One-cycle apply pulse per tracked register |
| gstat_o | output | 32 | Global write-status word |
| cstat_o | output | 32 | Count write-status word |
| lstat_o | output | 32*NCH | Per-channel write-status words, channel 0 in the low slice |

## Verification
The bench sweeps every tracked register and checks the cycle of its pulse and its status bit. A design with an off-by-one latency would show the pulse a cycle early or late, and a wrong bit map would light the wrong status position. It clears bits one at a time while other bits are set. This catches a clear that ignores its mask or wipes the whole word, and it checks that writing zeros changes nothing. It also places a clear in the exact cycle a bit is being set, which exposes a design that lets the clear win. Writes to untracked and neighbouring addresses, including the status words themselves, must give no pulse. Back-to-back writes must not merge or drop a pulse.

// File: rtl/wst_pkg.sv
// Package: address map, line indices and status bit positions shared
// by the write-status tracker and its checker. Assumes 32-bit data.
package wst_pkg;
    localparam int DW = 32;

    // Line indices of the global tracked registers
    localparam int T_CNT_LO = 0;
    localparam int T_CNT_HI = 1;
    localparam int T_CMP_LO = 2;
    localparam int T_CMP_HI = 3;
    localparam int T_INCR   = 4;
    localparam int T_GCTL   = 5;
    localparam int NGLOB    = 6;

    // Per-channel line offsets
    localparam int L_TICK   = 0;
    localparam int L_ICNT   = 1;
    localparam int L_LCTL   = 2;
    localparam int NPERCH   = 3;

    // Global addresses
    localparam int A_CNT_LO = 'h100;
    localparam int A_CNT_HI = 'h104;
    localparam int A_CSTAT  = 'h110;
    localparam int A_CMP_LO = 'h200;
    localparam int A_CMP_HI = 'h204;
    localparam int A_INCR   = 'h208;
    localparam int A_GCTL   = 'h240;
    localparam int A_GSTAT  = 'h24C;

    // Channel window
    localparam int CH_BASE   = 'h300;
    localparam int CH_STRIDE = 'h100;
    localparam int O_TICK    = 'h00;
    localparam int O_ICNT    = 'h08;
    localparam int O_LCTL    = 'h20;
    localparam int O_LSTAT   = 'h40;

    // Status bit positions (decoded by software)
    localparam int B_CMP_LO = 0;
    localparam int B_CMP_HI = 1;
    localparam int B_INCR   = 2;
    localparam int B_GCTL   = 16;
    localparam int B_CNT_LO = 0;
    localparam int B_CNT_HI = 1;
    localparam int B_TICK   = 0;
    localparam int B_ICNT   = 1;
    localparam int B_LCTL   = 3;
endpackage

// File: rtl/wst_decode.sv
// Module: wst_decode
// Turns one bus write into a one-hot "tracked register written" vector
// and a per-line clear vector when a status word is written.
// Assumes at most one write per cycle; pure combinational.
module wst_decode
    import wst_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 12,
    parameter int NT  = NGLOB + NPERCH * NCH
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [NT-1:0] hit,
    output logic [NT-1:0] clr
);
    int a;

    // Address compare against the tracked list and the status words
    always_comb begin
        hit = '0;
        clr = '0;
        a   = int'(wr_addr);
        if (wr_en) begin
            if (a == A_CNT_LO) hit[T_CNT_LO] = 1'b1;
            if (a == A_CNT_HI) hit[T_CNT_HI] = 1'b1;
            if (a == A_CMP_LO) hit[T_CMP_LO] = 1'b1;
            if (a == A_CMP_HI) hit[T_CMP_HI] = 1'b1;
            if (a == A_INCR)   hit[T_INCR]   = 1'b1;
            if (a == A_GCTL)   hit[T_GCTL]   = 1'b1;
            if (a == A_CSTAT) begin
                clr[T_CNT_LO] = wr_data[B_CNT_LO];
                clr[T_CNT_HI] = wr_data[B_CNT_HI];
            end
            if (a == A_GSTAT) begin
                clr[T_CMP_LO] = wr_data[B_CMP_LO];
                clr[T_CMP_HI] = wr_data[B_CMP_HI];
                clr[T_INCR]   = wr_data[B_INCR];
                clr[T_GCTL]   = wr_data[B_GCTL];
            end
            for (int c = 0; c < NCH; c++) begin
                if (a == CH_BASE + CH_STRIDE * c + O_TICK)
                    hit[NGLOB + NPERCH * c + L_TICK] = 1'b1;
                if (a == CH_BASE + CH_STRIDE * c + O_ICNT)
                    hit[NGLOB + NPERCH * c + L_ICNT] = 1'b1;
                if (a == CH_BASE + CH_STRIDE * c + O_LCTL)
                    hit[NGLOB + NPERCH * c + L_LCTL] = 1'b1;
                if (a == CH_BASE + CH_STRIDE * c + O_LSTAT) begin
                    clr[NGLOB + NPERCH * c + L_TICK] = wr_data[B_TICK];
                    clr[NGLOB + NPERCH * c + L_ICNT] = wr_data[B_ICNT];
                    clr[NGLOB + NPERCH * c + L_LCTL] = wr_data[B_LCTL];
                end
            end
        end
    end
endmodule

// File: rtl/wst_delay.sv
// Module: wst_delay
// Fixed-latency shift pipeline standing in for the crossing into the
// timer clock. Output is the input delayed by LAT cycles. LAT >= 1.
module wst_delay #(
    parameter int NT  = 12,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] din,
    output logic [NT-1:0] dout
);
    logic [NT-1:0] stg [LAT];

    // First stage captures the decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar k = 1; k < LAT; k++) begin : g_stage
        // Each later stage shifts the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[LAT-1];
endmodule

// File: rtl/wst_sticky.sv
// Module: wst_sticky
// Sticky write-one-to-clear flags, one per tracked line. A set in the
// same cycle as a clear wins.
module wst_sticky #(
    parameter int NT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] set,
    input  logic [NT-1:0] clr,
    output logic [NT-1:0] q
);
    // Hold, clear by mask, then apply new sets on top
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/wst_tracker.sv
// Module: wst_tracker (top)
// Write completion tracker: decodes bus writes, delays them by LAT
// cycles into apply pulses, and keeps a sticky status bit per tracked
// register, laid out into the global, count and per-channel words.
// Assumes one write per cycle and NCH channels that fit in AW bits.
module wst_tracker
    import wst_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 12,
    parameter int LAT = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [31:0]                  wr_data,
    output logic [NGLOB+NPERCH*NCH-1:0]  apply_o,
    output logic [31:0]                  gstat_o,
    output logic [31:0]                  cstat_o,
    output logic [32*NCH-1:0]            lstat_o
);
    localparam int NT = NGLOB + NPERCH * NCH;

    logic [NT-1:0] hit;
    logic [NT-1:0] clr;
    logic [NT-1:0] st_q;

    wst_decode #(.NCH(NCH), .AW(AW), .NT(NT)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit),
        .clr     (clr)
    );

    wst_delay #(.NT(NT), .LAT(LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hit),
        .dout  (apply_o)
    );

    wst_sticky #(.NT(NT)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (apply_o),
        .clr   (clr),
        .q     (st_q)
    );

    // Place the shared global flags into their status words
    always_comb begin
        gstat_o = '0;
        cstat_o = '0;
        cstat_o[B_CNT_LO] = st_q[T_CNT_LO];
        cstat_o[B_CNT_HI] = st_q[T_CNT_HI];
        gstat_o[B_CMP_LO] = st_q[T_CMP_LO];
        gstat_o[B_CMP_HI] = st_q[T_CMP_HI];
        gstat_o[B_INCR]   = st_q[T_INCR];
        gstat_o[B_GCTL]   = st_q[T_GCTL];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Place one channel's flags into its status word
        always_comb begin
            lstat_o[32*c +: 32]         = '0;
            lstat_o[32*c + B_TICK]      = st_q[NGLOB + NPERCH*c + L_TICK];
            lstat_o[32*c + B_ICNT]      = st_q[NGLOB + NPERCH*c + L_ICNT];
            lstat_o[32*c + B_LCTL]      = st_q[NGLOB + NPERCH*c + L_LCTL];
        end
    end
endmodule

// File: rtl/wst_chk.sv
// Module: wst_chk
// Assertion checker bound to wst_tracker; watches apply pulses, the
// sticky flags and the global status word.
module wst_chk #(
    parameter int NT = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [NT-1:0] apply,
    input logic [NT-1:0] st,
    input logic [31:0]   gstat
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (st == '0 && apply == '0));

    // R2
    apply_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(apply));

    // R8
    gstat_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gstat & ~32'h0001_0007) == 32'h0);

    for (genvar i = 0; i < NT; i++) begin : g_bit
        // R3 R6
        set_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            apply[i] |=> st[i]);
        // R3
        rise_needs_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st[i]) |-> $past(apply[i]));
        // R4
        fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st[i]) |-> $past(wr_en));
    end
endmodule

bind wst_tracker wst_chk #(.NT(NT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .apply (apply_o),
    .st    (st_q),
    .gstat (gstat_o)
);

// File: tb/tb_wst_tracker.sv
module tb_wst_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 12;
    localparam int LAT = 3;
    localparam int NT  = 6 + 3 * NCH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [NT-1:0]     apply_o;
    logic [31:0]       gstat_o;
    logic [31:0]       cstat_o;
    logic [32*NCH-1:0] lstat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [NT-1:0] exp_st = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wst_tracker #(.NCH(NCH), .AW(AW), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .apply_o(apply_o), .gstat_o(gstat_o),
        .cstat_o(cstat_o), .lstat_o(lstat_o)
    );

    // Address of tracked line i (R2)
    function automatic int taddr(int i);
        int c, k;
        case (i)
            0: return 'h100;
            1: return 'h104;
            2: return 'h200;
            3: return 'h204;
            4: return 'h208;
            5: return 'h240;
            default: begin
                c = (i - 6) / 3;
                k = (i - 6) % 3;
                return 'h300 + 'h100 * c + ((k == 0) ? 0 : (k == 1) ? 'h08 : 'h20);
            end
        endcase
    endfunction

    // Status word address of line i (R4)
    function automatic int saddr(int i);
        if (i < 2) return 'h110;
        if (i < 6) return 'h24C;
        return 'h340 + 'h100 * ((i - 6) / 3);
    endfunction

    // Bit position of line i in its status word (R3)
    function automatic int sbit(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 0;
            3: return 1;
            4: return 2;
            5: return 16;
            default: return ((i - 6) % 3 == 0) ? 0 : ((i - 6) % 3 == 1) ? 1 : 3;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(int addr);
        logic [31:0] w = '0;
        for (int i = 0; i < NT; i++)
            if (saddr(i) == addr && exp_st[i]) w[sbit(i)] = 1'b1;
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_status(string req);
        check(req, gstat_o, exp_word('h24C), "gstat");
        check(req, cstat_o, exp_word('h110), "cstat");
        for (int c = 0; c < NCH; c++)
            check(req, lstat_o[32*c +: 32], exp_word('h340 + 'h100*c), "lstat");
    endtask

    task automatic bus_write(int addr, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write a tracked line and check pulse cycle and status bit (R2, R3)
    task automatic write_tracked(int i);
        bus_write(taddr(i), 32'hA5A5_0000 + 32'(i));
        repeat (LAT - 1) begin
            check("R2", 32'(apply_o), 32'h0, "apply early");
            check_status("R3");
            @(negedge clk);
        end
        check("R2", 32'(apply_o), 32'h1 << i, "apply pulse");
        check_status("R3");
        @(negedge clk);
        exp_st[i] = 1'b1;
        check("R2", 32'(apply_o), 32'h0, "apply one cycle");
        check_status("R3");
    endtask

    task automatic write_untracked(int addr, logic [31:0] data);
        bus_write(addr, data);
        repeat (LAT + 1) begin
            check("R5", 32'(apply_o), 32'h0, "apply on untracked");
            @(negedge clk);
        end
        check_status("R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        check("R1", 32'(apply_o), 32'h0, "apply in reset");
        check_status("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R8: each tracked line sets its own bit and stays set
        for (int i = 0; i < NT; i++) write_tracked(i);
        repeat (5) @(negedge clk);
        check_status("R3");

        // R4: zeros leave bits alone
        bus_write('h24C, 32'h0);
        bus_write('h110, 32'h0);
        for (int c = 0; c < NCH; c++) bus_write('h340 + 'h100*c, 32'h0);
        @(negedge clk);
        check_status("R4");

        // R4: clear one bit at a time, others must stay
        for (int i = 0; i < NT; i++) begin
            bus_write(saddr(i), 32'h1 << sbit(i));
            exp_st[i] = 1'b0;
            check_status("R4");
        end

        // R5: untracked addresses, including neighbours and status words
        write_untracked('h000, 32'hFFFF_FFFF);
        write_untracked('h10C, 32'h1);
        write_untracked('h20C, 32'h1);
        write_untracked('h244, 32'h1);
        write_untracked('h248, 32'h1);
        write_untracked('h24C, 32'hFFFF_FFFF);
        write_untracked('h110, 32'hFFFF_FFFF);
        for (int c = 0; c < NCH; c++) begin
            write_untracked('h304 + 'h100*c, 32'h1);
            write_untracked('h330 + 'h100*c, 32'h1);
            write_untracked('h334 + 'h100*c, 32'h1);
            write_untracked('h340 + 'h100*c, 32'hFFFF_FFFF);
        end

        // R6: clear sampled in the same cycle as the set
        for (int i = 0; i < NT; i++) begin
            bus_write(taddr(i), 32'h0);
            repeat (LAT - 1) @(negedge clk);
            wr_en = 1'b1;
            wr_addr = AW'(saddr(i));
            wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            wr_en = 1'b0;
            exp_st[i] = 1'b1;
            check_status("R6");
            bus_write(saddr(i), 32'hFFFF_FFFF);
            exp_st[i] = 1'b0;
            check_status("R4");
        end

        // R7: back-to-back writes to two different lines
        for (int i = 0; i + 1 < NT; i += 2) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(taddr(i)); wr_data = 32'h1;
            @(negedge clk);
            wr_addr = AW'(taddr(i+1));
            @(negedge clk);
            wr_en = 1'b0;
            repeat (LAT - 2) @(negedge clk);
            check("R7", 32'(apply_o), 32'h1 << i, "first pulse");
            @(negedge clk);
            check("R7", 32'(apply_o), 32'h1 << (i+1), "second pulse");
            exp_st[i] = 1'b1;
            check_status("R7");
            @(negedge clk);
            exp_st[i+1] = 1'b1;
            check_status("R7");
        end

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_st = '0;
        check("R1", 32'(apply_o), 32'h0, "apply after reset");
        check_status("R1");
        rst_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule